// File: doc/BRIEF.md
# Transceiver Status Flag Controller

This block is the digital supervisor of a bus transceiver. It decodes two mode-select pins into an operating mode and adds a sleep state that the block enters on its own. It keeps five internal status flags: wake-up, wake source, power-on, local failure and bus failure. It also keeps a supply undervoltage flag with its own waiting timer. A single active-low status pin shows one of the status flags. Which flag appears depends on the current mode, on the mode that came before it, and on how many recessive-going transmit edges have been seen since normal mode was last entered.

The analog comparators, the bus driver and receiver, and the failure detectors are not part of the block. They appear only as digital inputs. All filter and waiting times are counted in clock cycles and set by parameters.

A digital core uses the status pin to read back the reason for a wake-up and the fault state. It also uses the sleep request and the inhibit output to switch the node's voltage regulators.

Top module: `xcvr_flag_ctrl`

## Requirements
- R1: After reset the mode is standby, the power-on flag is set, and all other flags are clear. The outputs are `status_n`=1, `sleep_req`=0 and `inhibit`=1.
- R2: Pin decode uses (`mode_sel`,`mode_en`). The code 11 selects normal, 10 power-on/listen-only, 01 go-to-sleep and 00 standby. The mode updates at the clock edge after the pins change. `status_n` is active-low, so 0 means the selected flag is set. In standby, go-to-sleep and sleep, `status_n` shows the wake-up flag.
- R3: In normal mode, `status_n` shows the wake-source flag until the fourth rising (dominant 0 to recessive 1) edge of `txd` has been sampled. From that edge on, it shows the bus-failure flag. The edge count saturates at EDGE_LIMIT=4 and is reset to 0 each time normal mode is entered.
- R4: In power-on/listen-only mode entered from normal mode, `status_n` shows the power-on flag. When that mode is entered from any other mode, `status_n` shows the local-failure flag.
- R5: A local wake-up request occurs on the WAKE_FILT-th consecutive sampled edge at which `wake_in` differs from its last accepted level. A shorter change has no effect.
- R6: A remote wake-up request occurs on the BUS_FILT-th consecutive sampled edge with `rxd`=0 (dominant). There is one request per dominant run.
- R7: A wake-up request sets the wake-up flag only in standby, go-to-sleep or sleep mode. A local request that sets it also sets the wake-source flag. The wake-up flag is cleared on entering normal mode. The wake-source flag is cleared on leaving normal mode.
- R8: The power-on flag is set when `bat_pwon_low` returns to 0 after having been 1. It is cleared on entering normal mode. While it is set, go-to-sleep does not lead to sleep.
- R9: After go-to-sleep has been held for SLEEP_HOLD edges, the block enters sleep. In sleep, `sleep_req`=1 and `inhibit`=0.
- R10: `supply_uv`=1 sets the undervoltage flag, and the mode becomes sleep at the following edge. For UV_WAIT edges after that, wake-up requests are blocked from setting the wake-up flag. After the wait, a wake-up request sets the wake-up flag and clears the undervoltage flag.
- R11: Setting the power-on flag clears the undervoltage flag at once, even during the waiting time.
- R12: The bus-failure flag is cleared on entering normal mode. The local-failure flag is cleared on entering normal mode. It is also cleared when `rxd`=0 while `txd`=1, but only if `local_fail_in` is 0.
- R13: Sleep is left for the pin-selected mode when the wake-up or power-on flag is set, or when the pins select normal or listen-only. Selecting standby or go-to-sleep keeps the block asleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 1 | Mode select pin (1 = normal or listen-only group) |
| mode_en | input | 1 | Mode enable pin |
| txd | input | 1 | Transmit data, 0 = dominant |
| rxd | input | 1 | Received bus state, 0 = dominant |
| wake_in | input | 1 | Sampled local wake pin |
| bat_pwon_low | input | 1 | Battery below power-on threshold |
| supply_uv | input | 1 | Any supply below its undervoltage threshold |
| local_fail_in | input | 1 | A local failure is present |
| bus_fail_in | input | 1 | Bus failure detected |
| status_n | output | 1 | Selected flag, active low |
| sleep_req | output | 1 | Sleep mode active |
| inhibit | output | 1 | Regulator enable, low in sleep |

## Verification
Each flag is a register, and `status_n` decodes those registers combinationally together with the registered mode. A flag change or a mode change is therefore visible one edge after the stimulus that causes it. The undervoltage flag reaches `sleep_req` one edge later still, because the mode follows the flag. The filters act on the exact edge that completes their count: the WAKE_FILT-th edge for a local request, the BUS_FILT-th for a remote one, the fifth edge after go-to-sleep entry, and the fourth `txd` rise. The bench drives inputs on falling edges and samples on the next falling edge. It counts rising edges from the drive point, and probes one edge short of each boundary as well as on the boundary itself.

// File: rtl/xcvr_flag_ctrl.sv
module xcvr_flag_ctrl #(
  parameter int WAKE_FILT  = 4,
  parameter int BUS_FILT   = 6,
  parameter int UV_WAIT    = 10,
  parameter int SLEEP_HOLD = 5,
  parameter int EDGE_LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_sel,
  input  logic mode_en,
  input  logic txd,
  input  logic rxd,
  input  logic wake_in,
  input  logic bat_pwon_low,
  input  logic supply_uv,
  input  logic local_fail_in,
  input  logic bus_fail_in,
  output logic status_n,
  output logic sleep_req,
  output logic inhibit
);
  localparam int WW = $clog2(WAKE_FILT + 1);
  localparam int BW = $clog2(BUS_FILT + 1);
  localparam int UW = $clog2(UV_WAIT + 1);
  localparam int GW = $clog2(SLEEP_HOLD + 1);
  localparam int EW = $clog2(EDGE_LIMIT + 1);

  typedef enum logic [2:0] {M_STBY, M_GOSLP, M_LISTEN, M_NORM, M_SLEEP} mode_t;

  mode_t op_mode, mode_nx, pin_mode;
  logic wake_ref, bat_low_seen, txd_q, from_norm;
  logic wake_flag, wsrc_flag, pwon_flag, lf_flag, bus_flag, uv_flag;
  logic [WW-1:0] wk_cnt;
  logic [BW-1:0] bus_cnt;
  logic [UW-1:0] uv_cnt;
  logic [GW-1:0] gs_cnt;
  logic [EW-1:0] edge_cnt;
  logic sel_flag;

  assign pin_mode = mode_sel ? (mode_en ? M_NORM : M_LISTEN)
                             : (mode_en ? M_GOSLP : M_STBY);

  wire wk_diff    = wake_in != wake_ref;
  wire local_req  = wk_diff && (wk_cnt == WW'(WAKE_FILT - 1));
  wire remote_req = !rxd && (bus_cnt == BW'(BUS_FILT - 1));
  wire wake_req   = local_req || remote_req;
  wire uv_run     = uv_flag && (uv_cnt != UW'(UV_WAIT));
  wire pwon_set   = bat_low_seen && !bat_pwon_low;
  wire wake_ok    = (op_mode == M_STBY || op_mode == M_GOSLP || op_mode == M_SLEEP) && !uv_run;
  wire wake_set   = wake_req && wake_ok;
  wire uv_clr     = pwon_set || (uv_flag && !uv_run && wake_req);
  wire enter_norm = (mode_nx == M_NORM) && (op_mode != M_NORM);
  wire leave_norm = (mode_nx != M_NORM) && (op_mode == M_NORM);
  wire gs_done    = (gs_cnt == GW'(SLEEP_HOLD - 1));

  always_comb begin
    if (uv_flag)
      mode_nx = M_SLEEP;
    else if (op_mode == M_SLEEP)
      mode_nx = (wake_flag || pwon_flag || pin_mode == M_NORM || pin_mode == M_LISTEN)
                ? pin_mode : M_SLEEP;
    else if (op_mode == M_GOSLP && pin_mode == M_GOSLP && gs_done && !wake_flag && !pwon_flag)
      mode_nx = M_SLEEP;
    else
      mode_nx = pin_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_mode   <= M_STBY;
      gs_cnt    <= '0;
      from_norm <= 1'b0;
    end else begin
      op_mode <= mode_nx;
      if (op_mode == M_GOSLP && pin_mode == M_GOSLP) begin
        if (!gs_done) gs_cnt <= gs_cnt + 1'b1;
      end else
        gs_cnt <= '0;
      if (mode_nx == M_LISTEN && op_mode != M_LISTEN)
        from_norm <= (op_mode == M_NORM);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_ref <= 1'b0;
      wk_cnt   <= '0;
      bus_cnt  <= '0;
    end else begin
      if (!wk_diff)
        wk_cnt <= '0;
      else if (local_req) begin
        wk_cnt   <= '0;
        wake_ref <= wake_in;
      end else
        wk_cnt <= wk_cnt + 1'b1;
      if (rxd)
        bus_cnt <= '0;
      else if (bus_cnt != BW'(BUS_FILT))
        bus_cnt <= bus_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uv_flag      <= 1'b0;
      uv_cnt       <= '0;
      bat_low_seen <= 1'b0;
      pwon_flag    <= 1'b1;
    end else begin
      if (uv_clr) begin
        uv_flag <= 1'b0;
        uv_cnt  <= '0;
      end else begin
        if (supply_uv) uv_flag <= 1'b1;
        if (uv_run) uv_cnt <= uv_cnt + 1'b1;
      end
      if (bat_pwon_low) bat_low_seen <= 1'b1;
      else if (pwon_set) bat_low_seen <= 1'b0;
      if (enter_norm) pwon_flag <= 1'b0;
      else if (pwon_set) pwon_flag <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_flag <= 1'b0;
      wsrc_flag <= 1'b0;
      bus_flag  <= 1'b0;
      lf_flag   <= 1'b0;
      txd_q     <= 1'b1;
      edge_cnt  <= '0;
    end else begin
      txd_q <= txd;
      if (enter_norm) wake_flag <= 1'b0;
      else if (wake_set) wake_flag <= 1'b1;
      if (leave_norm) wsrc_flag <= 1'b0;
      else if (wake_set && local_req) wsrc_flag <= 1'b1;
      if (enter_norm) bus_flag <= 1'b0;
      else if (bus_fail_in) bus_flag <= 1'b1;
      if (local_fail_in) lf_flag <= 1'b1;
      else if (enter_norm || (!rxd && txd)) lf_flag <= 1'b0;
      if (enter_norm)
        edge_cnt <= '0;
      else if (op_mode == M_NORM && !txd_q && txd && edge_cnt != EW'(EDGE_LIMIT))
        edge_cnt <= edge_cnt + 1'b1;
    end
  end

  always_comb begin
    case (op_mode)
      M_NORM:   sel_flag = (edge_cnt == EW'(EDGE_LIMIT)) ? bus_flag : wsrc_flag;
      M_LISTEN: sel_flag = from_norm ? pwon_flag : lf_flag;
      default:  sel_flag = wake_flag;
    endcase
  end

  assign status_n  = !sel_flag;
  assign sleep_req = (op_mode == M_SLEEP);
  assign inhibit   = (op_mode != M_SLEEP);

  AST_EDGE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt <= EW'(EDGE_LIMIT)); // R3
  AST_WAKE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> ($past(op_mode) != M_NORM && $past(op_mode) != M_LISTEN)); // R7
  AST_PWON_NORM: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == M_NORM && $past(op_mode) != M_NORM) |-> !pwon_flag); // R8
  AST_NO_SLEEP_PWON: assert property (@(posedge clk) disable iff (!rst_n)
    (op_mode == M_SLEEP && $past(op_mode) == M_GOSLP && !$past(uv_flag)) |-> !$past(pwon_flag)); // R8
  AST_UV_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |=> sleep_req); // R10
  AST_WAKE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_flag) |-> !$past(uv_run)); // R10
endmodule

// File: tb/xcvr_flag_ctrl_tb.sv
module xcvr_flag_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_sel = 0, mode_en = 0, txd = 1, rxd = 1, wake_in = 0;
  logic bat_pwon_low = 0, supply_uv = 0, local_fail_in = 0, bus_fail_in = 0;
  logic status_n, sleep_req, inhibit;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr_flag_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .mode_en(mode_en),
    .txd(txd), .rxd(rxd), .wake_in(wake_in), .bat_pwon_low(bat_pwon_low),
    .supply_uv(supply_uv), .local_fail_in(local_fail_in), .bus_fail_in(bus_fail_in),
    .status_n(status_n), .sleep_req(sleep_req), .inhibit(inhibit));

  // {mode_sel, mode_en, expected status_n, expected sleep_req}
  localparam logic [3:0] VEC [5] = '{4'b0010, 4'b1000, 4'b1110, 4'b1010, 4'b0110};

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic pins(input logic s, input logic e);
    mode_sel = s; mode_en = e;
  endtask

  task automatic txd_rises(input int n);
    for (int i = 0; i < n; i++) begin
      txd = 0; tick(1); txd = 1; tick(1);
    end
  endtask

  initial begin
    tick(2);
    rst_n = 1;
    tick(1);
    chk(status_n, 1, "R1 status after reset");
    chk(sleep_req, 0, "R1 sleep_req after reset");
    chk(inhibit, 1, "R1 inhibit after reset");

    local_fail_in = 1; tick(1); local_fail_in = 0;
    for (int i = 0; i < 5; i++) begin
      pins(VEC[i][3], VEC[i][2]);
      tick(1);
      chk(status_n, VEC[i][1], $sformatf("R2 R4 vector %0d status", i));
      chk(sleep_req, VEC[i][0], $sformatf("R2 vector %0d sleep", i));
    end

    // R3: wake source until fourth txd rise, then bus failure
    pins(1, 1); tick(1);
    bus_fail_in = 1; tick(1); bus_fail_in = 0;
    txd_rises(3);
    chk(status_n, 1, "R3 after third txd rise");
    txd_rises(1);
    chk(status_n, 0, "R3 after fourth txd rise");
    pins(0, 0); tick(1); pins(1, 1); tick(1);
    bus_fail_in = 1; tick(1); bus_fail_in = 0;
    chk(status_n, 1, "R3 edge count reset on normal entry");
    txd_rises(4);
    chk(status_n, 0, "R3 bus flag shown after recount");
    pins(0, 0); tick(1); pins(1, 1); tick(1);
    txd_rises(4);
    chk(status_n, 1, "R12 bus flag cleared on normal entry");

    // R5: local wake filter
    pins(0, 0); tick(1);
    wake_in = 1; tick(3); wake_in = 0; tick(1);
    chk(status_n, 1, "R5 short wake pulse ignored");
    wake_in = 1; tick(3);
    chk(status_n, 1, "R5 one edge before filter");
    tick(1);
    chk(status_n, 0, "R5 wake flag on filter edge");
    pins(1, 1); tick(1);
    chk(status_n, 0, "R7 wake source shown in normal");
    pins(0, 0); tick(1);
    chk(status_n, 1, "R7 wake flag cleared by normal entry");

    // R7: no wake flag in normal
    pins(1, 1); tick(1);
    wake_in = 0; tick(5);
    pins(0, 0); tick(1);
    chk(status_n, 1, "R7 wake in normal ignored");

    // R6: remote wake filter
    rxd = 0; tick(5); rxd = 1; tick(1);
    chk(status_n, 1, "R6 short dominant ignored");
    rxd = 0; tick(5);
    chk(status_n, 1, "R6 one edge before filter");
    tick(1);
    chk(status_n, 0, "R6 remote wake sets flag");
    rxd = 1;

    // R9: go-to-sleep hold
    pins(1, 1); tick(1);
    pins(0, 1); tick(5);
    chk(sleep_req, 0, "R9 before hold time");
    tick(1);
    chk(sleep_req, 1, "R9 sleep after hold");
    chk(inhibit, 0, "R9 inhibit off in sleep");

    // R13: stay asleep on standby pins, leave on wake
    pins(0, 0); tick(2);
    chk(sleep_req, 1, "R13 standby pins keep sleep");
    wake_in = 1; tick(4);
    chk(status_n, 0, "R13 wake flag in sleep");
    tick(1);
    chk(sleep_req, 0, "R13 sleep left on wake");
    chk(inhibit, 1, "R13 inhibit back on");

    // R8: power-on flag
    pins(1, 1); tick(1); pins(1, 0); tick(1);
    bat_pwon_low = 1; tick(1); bat_pwon_low = 0; tick(1);
    chk(status_n, 0, "R8 pwon flag shown in listen from normal");
    pins(0, 1); tick(10);
    chk(sleep_req, 0, "R8 pwon blocks sleep");
    pins(1, 1); tick(1); pins(1, 0); tick(1);
    chk(status_n, 1, "R8 pwon cleared by normal entry");

    // R10: undervoltage
    pins(0, 0); tick(1);
    supply_uv = 1; tick(1);
    chk(sleep_req, 0, "R10 mode one edge behind flag");
    supply_uv = 0; tick(1);
    chk(sleep_req, 1, "R10 undervoltage forces sleep");
    chk(inhibit, 0, "R10 inhibit off");
    rxd = 0; tick(6); rxd = 1;
    chk(status_n, 1, "R10 wake blocked during wait");
    tick(4);
    chk(sleep_req, 1, "R10 still asleep after wait");
    wake_in = 0; tick(4);
    chk(status_n, 0, "R10 wake after wait sets flag");
    tick(1);
    chk(inhibit, 1, "R10 undervoltage cleared by wake");

    // R11: power-on clears undervoltage at once
    supply_uv = 1; tick(1); supply_uv = 0; tick(1);
    chk(sleep_req, 1, "R11 asleep on undervoltage");
    bat_pwon_low = 1; tick(1); bat_pwon_low = 0; tick(1);
    chk(sleep_req, 1, "R11 mode follows one edge later");
    tick(1);
    chk(inhibit, 1, "R11 pwon cleared undervoltage");

    // R12: local failure
    pins(1, 1); tick(1); pins(0, 0); tick(1);
    local_fail_in = 1; tick(1);
    pins(1, 0); rxd = 0; txd = 1; tick(2);
    chk(status_n, 0, "R12 local flag kept while failure present");
    local_fail_in = 0; tick(1);
    chk(status_n, 1, "R12 local flag cleared by rxd dominant");
    rxd = 1; pins(0, 0); tick(1);
    local_fail_in = 1; tick(1); local_fail_in = 0;
    pins(1, 0); tick(2);
    chk(status_n, 0, "R12 local flag held with rxd recessive");
    rxd = 0; tick(1);
    chk(status_n, 1, "R12 local flag cleared");
    rxd = 1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule